// File: doc/BRIEF.md
# Run-time configurable bus fault injector

This block is inserted on a register output or a wire bus inside a design under test and corrupts the bus on command. Its purpose is to emulate hardware faults during fault campaigns. A host first loads a configuration through a write strobe. The configuration holds an enable, a corruption model, a persistence choice, a bit mask that selects which bits are hit, and a trigger value.

A start strobe begins a run and restarts an internal cycle counter. When the counter equals the trigger value and the injector is enabled, the selected corruption is applied to the masked bits of the data flowing from `data_in` to `data_out`. A transient fault lasts one cycle. A permanent fault stays in force until the next reset, start or configuration write. An `injected` flag tells the host that the fault has fired in the current run.

The data path is purely combinational. As a result, the wrapper adds no latency whether a fault is present or not, and it can be placed on any bus without retiming the surrounding logic. A typical use is a single bit-flip on the inputs of a cipher's substitution stage during its final round cycle.

Top module: `fault_injector`

## Requirements
- R1: After a synchronous reset the configuration is cleared to disabled, `injected` is low, and `data_out` equals `data_in`.
- R2: When no fault is applied, `data_out` equals `data_in` in the same cycle, with no register in the path. This includes the case where the enable is clear.
- R3: A configuration write (`cfg_we` high at a rising edge) loads all configuration fields at that edge. The model codes are: 0 flip, 1 set, 2 clear, 3 stuck-at-0, 4 stuck-at-1. Codes 5 to 7 never inject and never raise `injected`.
- R4: Only bits whose mask bit is 1 are altered. Every other bit of `data_out` equals the same bit of `data_in`.
- R5: While a fault is applied, a masked bit is handled by model: flip inverts it, set and stuck-at-1 force it to 1, and clear and stuck-at-0 force it to 0.
- R6: The edge that samples `start` high zeroes the counter. The fault first takes effect in the cycle that begins `cfg_trigger` rising edges after that edge, so a trigger of 0 fires in the cycle right after the start edge.
- R7: With persistence 0 (transient), the flip, set and clear models corrupt exactly one cycle.
- R8: With persistence 1 (permanent), the fault stays applied from its first cycle until a reset, a start strobe or a configuration write.
- R9: The stuck-at models hold their fault like a permanent fault, whatever the persistence bit says.
- R10: A fault fires at most once per run. It never fires before the first start after reset. The counter saturates instead of wrapping.
- R11: `injected` rises in the first cycle the fault takes effect and stays high until the next start or reset. A configuration write does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Injection enable |
| cfg_model | input | 3 | Corruption model code |
| cfg_persist | input | 1 | 1 selects a permanent fault, 0 a transient fault |
| cfg_mask | input | WIDTH | Bit-location mask |
| cfg_trigger | input | CNT_W | Counter value at which the fault fires |
| start | input | 1 | Run start strobe; restarts the counter and clears the flag |
| data_in | input | WIDTH | Bus from the design under test |
| data_out | output | WIDTH | Bus forwarded to the design, possibly corrupted |
| injected | output | 1 | Fault has fired in this run |

## Verification
The data output is combinational, so in each counted cycle the bench drives `data_in` at the falling edge and compares `data_out` a moment later, within the same cycle. Configuration and start strobes are held across exactly one rising edge. Cycle index 0 is the cycle right after the start edge, and the expected corruption for cycle k is derived from k, the trigger value and the persistence. The bench compares `injected` at the same sampling point, since it rises combinationally in the first fault cycle. The bench checks clearing by a configuration write or a start strobe in the cycle right after the edge that samples the strobe.

// File: rtl/fi_pkg.sv
package fi_pkg;

  typedef enum logic [2:0] {
    FM_FLIP   = 3'd0,
    FM_SET    = 3'd1,
    FM_CLEAR  = 3'd2,
    FM_STUCK0 = 3'd3,
    FM_STUCK1 = 3'd4
  } fault_model_e;

  localparam int MODEL_W = 3;

  function automatic logic model_is_valid(input logic [MODEL_W-1:0] m);
    return m <= FM_STUCK1;
  endfunction

  function automatic logic model_is_stuck(input logic [MODEL_W-1:0] m);
    return (m == FM_STUCK0) || (m == FM_STUCK1);
  endfunction

endpackage

// File: rtl/fi_cfg_regs.sv
module fi_cfg_regs
  import fi_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 enable_i,
  input  logic [MODEL_W-1:0]   model_i,
  input  logic                 persist_i,
  input  logic [WIDTH-1:0]     mask_i,
  input  logic [CNT_W-1:0]     trigger_i,
  output logic [MODEL_W-1:0]   model_q,
  output logic [WIDTH-1:0]     mask_q,
  output logic [CNT_W-1:0]     trigger_q,
  output logic                 armed,
  output logic                 sticky
);

  logic enable_q;
  logic persist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      model_q   <= FM_FLIP;
      persist_q <= 1'b0;
      mask_q    <= '0;
      trigger_q <= '0;
    end else if (we) begin
      enable_q  <= enable_i;
      model_q   <= model_i;
      persist_q <= persist_i;
      mask_q    <= mask_i;
      trigger_q <= trigger_i;
    end
  end

  // Unknown model codes disarm the trigger entirely.
  assign armed  = enable_q & model_is_valid(model_q);
  assign sticky = persist_q | model_is_stuck(model_q);

endmodule

// File: rtl/fi_trigger.sv
module fi_trigger #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_we,
  input  logic             armed,
  input  logic             sticky,
  input  logic [CNT_W-1:0] trigger,
  output logic             apply,
  output logic             injected
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             hold;
  logic             flag;
  logic             fire;

  assign fire     = running & armed & ~done & (cnt == trigger);
  assign apply    = fire | hold;
  assign injected = fire | flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      hold    <= 1'b0;
      flag    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      done    <= 1'b0;
      hold    <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (running && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
      if (fire) begin
        done <= 1'b1;
        flag <= 1'b1;
        hold <= sticky;
      end
      // A configuration write drops any persisting fault.
      if (cfg_we) begin
        hold <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
  import fi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               apply,
  input  logic [MODEL_W-1:0] model,
  input  logic [WIDTH-1:0]   mask,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic faulty;
    always_comb begin
      case (model)
        FM_FLIP:              faulty = ~din[i];
        FM_SET,   FM_STUCK1:  faulty = 1'b1;
        FM_CLEAR, FM_STUCK0:  faulty = 1'b0;
        default:              faulty = din[i];
      endcase
    end
    assign dout[i] = (apply & mask[i]) ? faulty : din[i];
  end

endmodule

// File: rtl/fault_injector.sv
module fault_injector
  import fi_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic [2:0]       cfg_model,
  input  logic             cfg_persist,
  input  logic [WIDTH-1:0] cfg_mask,
  input  logic [CNT_W-1:0] cfg_trigger,
  input  logic             start,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             injected
);

  logic [MODEL_W-1:0] model_q;
  logic [WIDTH-1:0]   mask_q;
  logic [CNT_W-1:0]   trigger_q;
  logic               armed;
  logic               sticky;
  logic               fault_apply;

  fi_cfg_regs #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .enable_i  (cfg_enable),
    .model_i   (cfg_model),
    .persist_i (cfg_persist),
    .mask_i    (cfg_mask),
    .trigger_i (cfg_trigger),
    .model_q   (model_q),
    .mask_q    (mask_q),
    .trigger_q (trigger_q),
    .armed     (armed),
    .sticky    (sticky)
  );

  fi_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_we   (cfg_we),
    .armed    (armed),
    .sticky   (sticky),
    .trigger  (trigger_q),
    .apply    (fault_apply),
    .injected (injected)
  );

  fi_corrupt #(.WIDTH(WIDTH)) u_corrupt (
    .apply (fault_apply),
    .model (model_q),
    .mask  (mask_q),
    .din   (data_in),
    .dout  (data_out)
  );

endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] data_out,
  input logic             injected,
  input logic [WIDTH-1:0] mask,
  input logic [2:0]       model,
  input logic             apply
);

  // R1
  a_r1_reset_clears_flag: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !injected);

  // R2
  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (rst)
    !injected |-> data_out == data_in);

  // R4
  a_r4_unmasked_untouched: assert property (@(posedge clk) disable iff (rst)
    ((data_out ^ data_in) & ~mask) == '0);

  // R5
  a_r5_stuck0_forces_low: assert property (@(posedge clk) disable iff (rst)
    (apply && model == 3'd3) |-> (data_out & mask) == '0);

  // R5
  a_r5_stuck1_forces_high: assert property (@(posedge clk) disable iff (rst)
    (apply && model == 3'd4) |-> (data_out & mask) == mask);

  // R11
  a_r11_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (injected && !start) |=> injected);

endmodule

bind fault_injector fi_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .data_in  (data_in),
  .data_out (data_out),
  .injected (injected),
  .mask     (mask_q),
  .model    (model_q),
  .apply    (fault_apply)
);

// File: tb/test_fault_injector.sv
module test_fault_injector;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;
  localparam int CNT_W = 16;
  localparam int NV = 8;
  localparam int WATCHDOG = 150000;

  // Vector table: model, persistence, mask, trigger, data pattern
  localparam logic [2:0]  V_MODEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd5, 3'd1};
  localparam logic        V_PERS  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_MASK  [NV] = '{32'h0000_0001, 32'hF000_000F, 32'h00FF_FF00,
                                          32'h8000_0001, 32'h0F0F_0000, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0100};
  localparam int          V_TRIG  [NV] = '{3, 0, 5, 2, 1, 4, 1, 7};
  localparam logic [31:0] V_PAT   [NV] = '{32'hA5A5_5A5A, 32'h1234_5678, 32'hFFFF_FFFF,
                                          32'hDEAD_BEEF, 32'h0000_0000, 32'h0BAD_F00D,
                                          32'h5555_AAAA, 32'h0000_0000};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic             cfg_enable = 1'b0;
  logic [2:0]       cfg_model = 3'd0;
  logic             cfg_persist = 1'b0;
  logic [WIDTH-1:0] cfg_mask = '0;
  logic [CNT_W-1:0] cfg_trigger = '0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] data_in = '0;
  logic [WIDTH-1:0] data_out;
  logic             injected;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_injector #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_fault_injector (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_model(cfg_model), .cfg_persist(cfg_persist), .cfg_mask(cfg_mask),
    .cfg_trigger(cfg_trigger), .start(start), .data_in(data_in),
    .data_out(data_out), .injected(injected)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] corrupt(input logic [2:0] m, input logic [31:0] msk,
                                          input logic [31:0] d);
    if (m == 3'd0) return d ^ msk;
    if (m == 3'd1 || m == 3'd4) return d | msk;
    if (m == 3'd2 || m == 3'd3) return d & ~msk;
    return d;
  endfunction

  task automatic configure(input logic en, input logic [2:0] m, input logic p,
                           input logic [31:0] msk, input int trig);
    @(negedge clk);
    cfg_enable = en; cfg_model = m; cfg_persist = p; cfg_mask = msk;
    cfg_trigger = CNT_W'(trig); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Leaves the bench at the falling edge of cycle index 0.
  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();

    // R1 reset state, R2 same-cycle pass-through
    data_in = 32'hCAFE_0001;
    #1;
    chk("R1 injected after reset", {31'd0, injected}, 32'd0);
    chk("R1 R2 data after reset", data_out, 32'hCAFE_0001);
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      data_in = 32'h1111_0000 + k;
      #1;
      chk("R1 default config disabled", data_out, 32'h1111_0000 + k);
      @(negedge clk);
    end

    // Table-driven runs: R3 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      configure(1'b1, V_MODEL[v], V_PERS[v], V_MASK[v], V_TRIG[v]);
      pulse_start();
      for (int k = 0; k <= V_TRIG[v] + 3; k++) begin
        logic valid;
        logic stick;
        logic app;
        logic [31:0] d;
        logic [31:0] exp;
        valid = V_MODEL[v] <= 3'd4;
        stick = V_PERS[v] || V_MODEL[v] == 3'd3 || V_MODEL[v] == 3'd4;
        app   = valid && (k == V_TRIG[v] || (k > V_TRIG[v] && stick));
        d     = V_PAT[v] ^ {4{8'(k)}};
        exp   = app ? corrupt(V_MODEL[v], V_MASK[v], d) : d;
        data_in = d;
        #1;
        chk($sformatf("R4 R5 R6 R7 R8 R9 vec%0d cyc%0d data", v, k), data_out, exp);
        chk($sformatf("R3 R11 vec%0d cyc%0d injected", v, k), {31'd0, injected},
            {31'd0, valid && k >= V_TRIG[v]});
        @(negedge clk);
      end
    end

    // R2 enable clear: nothing ever fires
    configure(1'b0, 3'd0, 1'b1, 32'hFFFF_FFFF, 0);
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      data_in = 32'h2468_0000 + k;
      #1;
      chk("R2 disabled passes data", data_out, 32'h2468_0000 + k);
      chk("R2 disabled no flag", {31'd0, injected}, 32'd0);
      @(negedge clk);
    end

    // R8 R11 permanent fault dropped by a configuration write, flag kept
    configure(1'b1, 3'd0, 1'b1, 32'h0000_00FF, 0);
    pulse_start();
    data_in = 32'h0000_0000;
    #1;
    chk("R8 permanent active", data_out, 32'h0000_00FF);
    @(negedge clk);
    cfg_we = 1'b1;
    #1;
    chk("R8 still active before write edge", data_out, 32'h0000_00FF);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R8 cleared by cfg write", data_out, 32'h0000_0000);
    chk("R11 flag survives cfg write", {31'd0, injected}, 32'd1);

    // R8 R11 start clears permanent fault and flag; rearms
    configure(1'b1, 3'd2, 1'b1, 32'hFFFF_0000, 2);
    pulse_start();
    @(negedge clk); @(negedge clk);
    data_in = 32'hFFFF_FFFF;
    #1;
    chk("R8 clear model permanent", data_out, 32'h0000_FFFF);
    pulse_start();
    #1;
    chk("R8 start drops fault", data_out, 32'hFFFF_FFFF);
    chk("R11 start clears flag", {31'd0, injected}, 32'd0);

    // R1 mid-fault reset drops everything
    do_reset();
    #1;
    chk("R1 reset drops fault", data_out, 32'hFFFF_FFFF);
    chk("R1 reset clears flag", {31'd0, injected}, 32'd0);

    // R10 no fire without a start after reset
    configure(1'b1, 3'd0, 1'b1, 32'hFFFF_FFFF, 0);
    for (int k = 0; k < 4; k++) begin
      data_in = 32'h0F0F_0000 + k;
      #1;
      chk("R10 no fire before start", data_out, 32'h0F0F_0000 + k);
      @(negedge clk);
    end

    // R10 fires once; counter saturates past its range without refiring
    configure(1'b1, 3'd0, 1'b0, 32'h0000_0001, 2);
    pulse_start();
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 70000; k++) begin
        data_in = 32'(k) << 1;
        #1;
        if (data_out !== ((k == 2) ? ((32'(k) << 1) | 32'd1) : (32'(k) << 1))) bad++;
        @(negedge clk);
      end
      chk("R10 single fire over long run", 32'(bad), 32'd0);
      chk("R10 R11 flag still high", {31'd0, injected}, 32'd1);
    end

    finish_run();
  end

endmodule